// File: doc/BRIEF.md
# Compressed High-Resolution Sine Lookup

This block turns an 18-bit phase word into a 16-bit signed sine amplitude. It does not use one table with 2^18 entries. Instead it splits the phase into a coarse step and a fine offset and builds the result from the angle-sum identity. The coarse step reads a sine value and a cosine value from two small tables. The fine offset reads a small-angle sine from a third table. The amplitude is then the coarse sine plus the coarse cosine times the fine sine. That needs one hardware multiply per sample.

The block sits behind a phase accumulator in a digital synthesizer. It takes one phase per cycle with a valid flag. It returns one amplitude per cycle, a fixed number of cycles later, with a matching valid flag. All three tables are computed when the design is elaborated. Each has 512 entries, so each fits one block RAM.

The fine sine table stores values scaled up by 2^6, which keeps their precision. The product is shifted back down with round-to-nearest before the add. The sum is clamped to the signed 16-bit range.

Top module: `sine_split_lut`

## Requirements
- R1: `amp_valid` rises exactly 4 clock cycles after the cycle in which `phase_valid` was sampled high. A single-cycle input pulse gives a single-cycle output pulse.
- R2: Phase value p stands for the angle 2·π·p/2^18. Bits [17:9] select the coarse step and bits [8:0] the fine offset. The amplitude is two's complement, with +32767 meaning +1.0. Phase 0x10000 gives +32767 and phase 0x30000 gives -32767.
- R3: For every phase p, `amp` differs from round(32767·sin(2·π·p/2^18)) by at most 4 LSB.
- R4: When the fine offset bits [8:0] are zero, `amp` equals round(32767·sin(2·π·p/2^18)) exactly. Examples: phase 0 gives 0, phase 0x8000 gives 23170, phase 0x20000 gives 0, phase 0x28000 gives -23170.
- R5: The final sum is clamped to the 16-bit range. Phase 0x0FFFF gives +32767 and phase 0x2FFFF gives -32768.
- R6: A cycle with `phase_valid` low produces no output. `amp_valid` stays low and `amp` keeps its last value.
- R7: While `rst` is high, and in the first cycle after it, `amp_valid` is 0 and `amp` is 0. A reset applied while samples are in the pipeline discards them.
- R8: The block accepts a new phase on every cycle. Results leave in the order the phases arrived, and none are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 18 | Phase word (full turn = 2^18) |
| phase_valid | input | 1 | Phase qualifier |
| amp | output | 16 | Signed sine amplitude |
| amp_valid | output | 1 | Amplitude qualifier |

## Verification
The assertions check three things on every cycle. The valid flag must arrive four cycles after its input. Every table read must have the sign that its address's quadrant implies. The output register must clamp whenever the sum leaves the 16-bit range, and must hold its value in idle cycles.

Numerical accuracy can only be shown by the bench's scenarios. These are a streamed sweep over phases against a real-valued sine, exact values at coarse-step boundaries, and the two clamping phases next to the peaks. Result ordering under back-to-back input also comes only from the bench.

// File: rtl/sine_split_lut_pkg.sv
package sine_split_lut_pkg;

  typedef enum logic [1:0] {
    TBL_COARSE_SIN,
    TBL_COARSE_COS,
    TBL_FINE_SIN
  } tbl_kind_e;

  localparam real TWO_PI = 6.283185307179586;

  // symmetric round-to-nearest of a real value
  function automatic int round_near(input real x);
    if (x >= 0.0) return $rtoi($floor(x + 0.5));
    else          return -$rtoi($floor(-x + 0.5));
  endfunction

endpackage

// File: rtl/sine_split_rom.sv
module sine_split_rom
  import sine_split_lut_pkg::*;
#(
  parameter tbl_kind_e KIND    = TBL_COARSE_SIN,
  parameter int        ADDR_W  = 9,
  parameter int        DATA_W  = 16,
  parameter int        PHASE_W = 18,
  parameter int        FINE_SH = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [DATA_W-1:0] rd_data
);
  localparam int  DEPTH   = 1 << ADDR_W;
  localparam real AMP_MAX = real'((1 << (DATA_W - 1)) - 1);
  localparam real FINE_SC = real'(1 << (DATA_W - 1 + FINE_SH));
  localparam int  QTR     = DEPTH / 4;
  localparam int  HALF    = DEPTH / 2;

  logic signed [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real ang;
      int  v;
      if (KIND == TBL_FINE_SIN) begin
        ang = TWO_PI * real'(i) / real'(1 << PHASE_W);
        v   = round_near(FINE_SC * $sin(ang));
      end else if (KIND == TBL_COARSE_COS) begin
        ang = TWO_PI * real'(i) / real'(DEPTH);
        v   = round_near(AMP_MAX * $cos(ang));
      end else begin
        ang = TWO_PI * real'(i) / real'(DEPTH);
        v   = round_near(AMP_MAX * $sin(ang));
      end
      mem[i] = DATA_W'(v);
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // checking state: which address the held data came from
  logic              rd_ok;
  logic [ADDR_W-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok  <= 1'b0;
      addr_q <= '0;
    end else if (rd_en) begin
      rd_ok  <= 1'b1;
      addr_q <= rd_addr;
    end
  end

  logic want_pos, want_neg;
  always_comb begin
    want_pos = 1'b0;
    want_neg = 1'b0;
    if (KIND == TBL_FINE_SIN) begin
      want_pos = (int'(addr_q) > 0);
    end else if (KIND == TBL_COARSE_COS) begin
      want_pos = (int'(addr_q) < QTR) || (int'(addr_q) > 3 * QTR);
      want_neg = (int'(addr_q) > QTR) && (int'(addr_q) < 3 * QTR);
    end else begin
      want_pos = (int'(addr_q) > 0) && (int'(addr_q) < HALF);
      want_neg = (int'(addr_q) > HALF);
    end
  end

  assert_rom_pos_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && want_pos) |-> (rd_data > 0));
  assert_rom_neg_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && want_neg) |-> (rd_data < 0));

endmodule

// File: rtl/sine_split_fma.sv
module sine_split_fma #(
  parameter int AMP_W   = 16,
  parameter int FINE_SH = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [AMP_W-1:0] sin_a,
  input  logic signed [AMP_W-1:0] cos_a,
  input  logic signed [AMP_W-1:0] sin_b,
  output logic signed [AMP_W-1:0] amp,
  output logic                    amp_valid
);
  localparam int PROD_W = 2 * AMP_W;
  localparam int SUM_W  = AMP_W + 2;
  localparam int SHIFT  = AMP_W - 1 + FINE_SH;
  localparam logic signed [PROD_W-1:0] BIAS   = PROD_W'(1) <<< (SHIFT - 1);
  localparam logic signed [SUM_W-1:0]  SUM_HI = SUM_W'((1 << (AMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0]  SUM_LO = -SUM_W'(1 << (AMP_W - 1));
  localparam logic signed [AMP_W-1:0]  AMP_HI = SUM_HI[AMP_W-1:0];
  localparam logic signed [AMP_W-1:0]  AMP_LO = SUM_LO[AMP_W-1:0];

  // stage 3: multiply
  logic signed [PROD_W-1:0] cos_x, sinb_x, prod_q;
  logic signed [AMP_W-1:0]  sin_a_q;
  logic                     v3;
  assign cos_x  = PROD_W'(cos_a);
  assign sinb_x = PROD_W'(sin_b);

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= in_valid;
    if (in_valid) begin
      prod_q  <= cos_x * sinb_x;
      sin_a_q <= sin_a;
    end
  end

  // stage 4: round, add, clamp
  logic signed [PROD_W-1:0] prod_rnd;
  logic signed [SUM_W-1:0]  sum;
  logic signed [AMP_W-1:0]  sum_sat;
  assign prod_rnd = (prod_q + BIAS) >>> SHIFT;
  assign sum      = SUM_W'(sin_a_q) + SUM_W'(prod_rnd);

  always_comb begin
    if (sum > SUM_HI)      sum_sat = AMP_HI;
    else if (sum < SUM_LO) sum_sat = AMP_LO;
    else                   sum_sat = sum[AMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp       <= '0;
      amp_valid <= 1'b0;
    end else begin
      amp_valid <= v3;
      if (v3) amp <= sum_sat;
    end
  end

  assert_clamp_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (v3 && (sum > SUM_HI)) |=> (amp_valid && amp == AMP_HI));
  assert_clamp_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (v3 && (sum < SUM_LO)) |=> (amp_valid && amp == AMP_LO));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !v3 |=> (!amp_valid && $stable(amp)));

endmodule

// File: rtl/sine_split_lut.sv
module sine_split_lut
  import sine_split_lut_pkg::*;
#(
  parameter int PHASE_W  = 18,
  parameter int AMP_W    = 16,
  parameter int COARSE_W = 9,
  parameter int FINE_SH  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      phase,
  input  logic                    phase_valid,
  output logic signed [AMP_W-1:0] amp,
  output logic                    amp_valid
);
  localparam int FINE_W  = PHASE_W - COARSE_W;
  localparam int LATENCY = 4;

  // stage 1: address register
  logic [PHASE_W-1:0]  phase_q;
  logic                v1, v2;
  logic [COARSE_W-1:0] coarse_addr;
  logic [FINE_W-1:0]   fine_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= phase_valid;
      v2 <= v1;
    end
    if (phase_valid) phase_q <= phase;
  end

  assign coarse_addr = phase_q[PHASE_W-1:FINE_W];
  assign fine_addr   = phase_q[FINE_W-1:0];

  // stage 2: three table reads
  logic signed [AMP_W-1:0] tbl_out [3];

  for (genvar t = 0; t < 3; t++) begin : g_tbl
    localparam tbl_kind_e K = tbl_kind_e'(t);
    localparam int        AW = (K == TBL_FINE_SIN) ? FINE_W : COARSE_W;
    logic [AW-1:0] addr;
    if (K == TBL_FINE_SIN) begin : g_fine
      assign addr = fine_addr;
    end else begin : g_coarse
      assign addr = coarse_addr;
    end
    sine_split_rom #(
      .KIND(K), .ADDR_W(AW), .DATA_W(AMP_W),
      .PHASE_W(PHASE_W), .FINE_SH(FINE_SH)
    ) u_rom (
      .clk(clk), .rst(rst), .rd_en(v1),
      .rd_addr(addr), .rd_data(tbl_out[t])
    );
  end

  // stages 3 and 4
  sine_split_fma #(.AMP_W(AMP_W), .FINE_SH(FINE_SH)) u_fma (
    .clk(clk), .rst(rst), .in_valid(v2),
    .sin_a(tbl_out[TBL_COARSE_SIN]),
    .cos_a(tbl_out[TBL_COARSE_COS]),
    .sin_b(tbl_out[TBL_FINE_SIN]),
    .amp(amp), .amp_valid(amp_valid)
  );

  // cycles since reset, saturating, for the latency check
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (int'(since_rst) < LATENCY) since_rst <= since_rst + 3'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(since_rst) >= LATENCY) |-> (amp_valid == $past(phase_valid, 4)));
  assert_known_R3: assert property (@(posedge clk) disable iff (rst)
    amp_valid |-> !$isunknown(amp));

endmodule

// File: tb/sine_split_lut_test.sv
`timescale 1ns/1ps
module sine_split_lut_test;
  localparam int  PW       = 18;
  localparam int  NPH      = 1 << PW;
  localparam real SCALE    = 32767.0;
  localparam real PI2      = 6.283185307179586;
  localparam int  TOL      = 4;
  localparam int  WD_LIMIT = 150000;
  localparam int  NV       = 8;
  // phase, expected amplitude (exact)
  localparam int VEC_PH  [NV] = '{0, 32768, 65536, 131072, 163840, 196608, 65535, 196607};
  localparam int VEC_EXP [NV] = '{0, 23170, 32767, 0, -23170, -32767, 32767, -32768};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PW-1:0]     phase = '0;
  logic              phase_valid = 1'b0;
  logic signed [15:0] amp;
  logic              amp_valid;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  sine_split_lut uut (
    .clk(clk), .rst(rst), .phase(phase), .phase_valid(phase_valid),
    .amp(amp), .amp_valid(amp_valid)
  );

  function automatic int ref_amp(input int p);
    real x;
    x = SCALE * $sin(PI2 * real'(p) / real'(NPH));
    if (x >= 0.0) return $rtoi($floor(x + 0.5));
    else          return -$rtoi($floor(-x + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WD_LIMIT);
      summary();
    end
  end

  // single sample: drive one cycle, wait the latency, compare
  task automatic one_sample(input int p, input int exp, input string req);
    @(negedge clk);
    phase = PW'(p);
    phase_valid = 1'b1;
    @(negedge clk);
    phase_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(amp_valid == 1'b1, req, int'(amp_valid), 1);
    check(int'(amp) == exp, req, int'(amp), exp);
  endtask

  initial begin
    int ring [16];
    int wr = 0, rd = 0;
    // R7: reset state
    repeat (3) @(negedge clk);
    check(amp_valid == 1'b0, "R7", int'(amp_valid), 0);
    check(amp == 16'sd0, "R7", int'(amp), 0);
    rst = 1'b0;
    @(negedge clk);
    check(amp_valid == 1'b0 && amp == 16'sd0, "R7", int'(amp), 0);

    // R2 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (i >= 6) ? "R5" : ((i == 2 || i == 5) ? "R2" : "R4");
      one_sample(VEC_PH[i], VEC_EXP[i], tag);
    end

    // R1: latency and single-cycle pulse
    begin
      int n = 0;
      @(negedge clk);
      phase = PW'(32768);
      phase_valid = 1'b1;
      @(negedge clk);
      phase_valid = 1'b0;
      n = 1;
      while (!amp_valid && n < 10) begin
        @(negedge clk);
        n++;
      end
      check(n == 4, "R1", n, 4);
      @(negedge clk);
      check(amp_valid == 1'b0, "R1", int'(amp_valid), 0);
    end

    // R6: idle cycles change nothing
    one_sample(65536, 32767, "R6");
    phase = '0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      phase = PW'(k * 1000 + 7);
      check(amp_valid == 1'b0 && amp == 16'sd32767, "R6", int'(amp), 32767);
    end

    // R7: reset with samples in flight
    @(negedge clk);
    phase = PW'(100000);
    phase_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    phase_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(amp_valid == 1'b0 && amp == 16'sd0, "R7", int'(amp_valid), 0);
    end

    // R3 R8: back-to-back sweep, stride 3 covers every fine offset
    for (int p = 0; p < NPH + 12; p += 3) begin
      @(negedge clk);
      if (amp_valid) begin
        int e;
        e = ref_amp(ring[rd % 16]);
        check((int'(amp) - e <= TOL) && (e - int'(amp) <= TOL), "R3", int'(amp), e);
        rd++;
      end
      if (p < NPH) begin
        phase = PW'(p);
        phase_valid = 1'b1;
        ring[wr % 16] = p;
        wr++;
      end else begin
        phase_valid = 1'b0;
      end
    end
    check(rd == wr, "R8", rd, wr);
    summary();
  end
endmodule